// File: doc/BRIEF.md
# CAN Message Buffer Status Bank

This block keeps three status flags for each of a set of CAN message buffers (32 by default): a ready flag, a transmit-request flag and a data-updated flag. Software reads one buffer's flags as a status byte. It cannot write that byte directly. Every software change goes through a 16-bit set/clear word that names the flags to raise and the flags to drop.

The CAN protocol engine sends per-buffer event strobes into the bank: a data frame was stored, a remote frame arrived, or a transmission finished. These events move the flags automatically. The bank returns per-buffer masks to the engine: which buffers may transmit, which of those should send a remote frame, and which may accept a frame. It also raises a one-cycle overwrite strobe that feeds the overrun bit in each buffer's control register.

A per-buffer direction input marks a buffer as a transmit buffer or a receive buffer. This input decides how the data-updated flag and the transmit request are read.

Top module: `can_msg_status_bank`

## Requirements
- R1: The status byte of the buffer at `addr_i` appears on `rd_data_o`. Bit 0 is the ready flag, bit 1 is the transmit-request flag and bit 2 is the data-updated flag. Bits 7 to 3 always read 0.
- R2: A direct status write (`stat_wr_en_i`) changes no flag, whatever its data.
- R3: A set/clear write (`sc_wr_en_i`) acts on the buffer at `addr_i`. Word bit k clears flag k and word bit 8+k sets flag k, for k = 0 to 2. If both bits are 1, or both are 0, flag k is unchanged. The new value is visible after the next clock edge.
- R4: `tx_elig_o[n]` is 1 exactly when buffer n has both its ready flag and its transmit-request flag set. `tx_remote_o[n]` is 1 when buffer n is eligible and is a receive buffer (`buf_is_tx_i[n]`=0).
- R5: `rx_elig_o[n]` equals buffer n's ready flag. A frame event for a buffer whose ready flag is 0 has no effect.
- R6: A data frame stored into a ready receive buffer (`rx_store_i[n]`) sets its data-updated flag. The flag stays 1 until it is cleared.
- R7: If a data frame is stored into a ready receive buffer whose data-updated flag is already 1, `ovr_o[n]` pulses for exactly one cycle, in the cycle after the event. Transmit buffers never pulse.
- R8: A remote frame received by a ready transmit buffer (`rx_remote_i[n]`) sets its data-updated flag. `tx_done_i[n]` on a transmit buffer clears that flag.
- R9: `tx_done_i[n]` clears buffer n's transmit-request flag.
- R10: When a hardware event and a set/clear write target the same flag in the same cycle, the hardware event wins.
- R11: After reset every flag is 0, every mask is 0 and no overwrite pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | IDX_W (5) | Buffer index for the read, the direct write and the set/clear write |
| rd_data_o | output | 8 | Status byte of the selected buffer |
| stat_wr_en_i | input | 1 | Direct status write strobe (ignored) |
| stat_wr_data_i | input | 8 | Direct status write data (ignored) |
| sc_wr_en_i | input | 1 | Set/clear write strobe |
| sc_wr_data_i | input | 16 | Set/clear word: high byte sets, low byte clears |
| buf_is_tx_i | input | NUM_BUF | 1 marks the buffer as a transmit buffer |
| rx_store_i | input | NUM_BUF | Data frame stored per buffer |
| rx_remote_i | input | NUM_BUF | Remote frame received per buffer |
| tx_done_i | input | NUM_BUF | Transmission completed per buffer |
| tx_elig_o | output | NUM_BUF | Buffer may transmit |
| tx_remote_o | output | NUM_BUF | Eligible buffer should send a remote frame |
| rx_elig_o | output | NUM_BUF | Buffer may accept a frame |
| ovr_o | output | NUM_BUF | One-cycle overwrite pulse |

## Verification
A protocol engine event and a software set/clear write can land on the same flag in the same clock cycle. The bench provokes this in two cases:
- It asserts the transmit-done strobe in the same cycle as a write that sets the transmit-request flag. The status byte read afterwards must show the flag cleared.
- It asserts a frame-store strobe in the same cycle as a write that clears the data-updated flag. The status byte must show the flag set.

In both cases the hardware event must win.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;
  localparam int RDY_BIT = 0;
  localparam int TRQ_BIT = 1;
  localparam int DN_BIT  = 2;
  localparam int FLAG_W  = 3;
  localparam int SET_OFS = 8;
endpackage

// File: rtl/cs_sc_decode.sv
module cs_sc_decode
  import can_stat_pkg::*;
#(
  parameter int NUM_BUF = 32,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic                           sc_wr_en_i,
  input  logic [IDX_W-1:0]               addr_i,
  input  logic [15:0]                    sc_wr_data_i,
  output logic [NUM_BUF-1:0][FLAG_W-1:0] set_o,
  output logic [NUM_BUF-1:0][FLAG_W-1:0] clr_o
);
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_dec
    logic hit;
    assign hit      = sc_wr_en_i && (addr_i == IDX_W'(g));
    assign set_o[g] = hit ? sc_wr_data_i[SET_OFS +: FLAG_W] : '0;
    assign clr_o[g] = hit ? sc_wr_data_i[FLAG_W-1:0] : '0;
  end
endmodule

// File: rtl/cs_flag_cell.sv
module cs_flag_cell
  import can_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic              is_tx_i,
  input  logic              rx_store_i,
  input  logic              rx_remote_i,
  input  logic              tx_done_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              ovr_o
);
  logic rdy_q, trq_q, dn_q, ovr_q;
  logic rdy_d, trq_d, dn_d, ovr_d;
  logic rx_ok;

  function automatic logic sw_next(logic q, logic s, logic c);
    if (s && !c) return 1'b1;
    if (c && !s) return 1'b0;
    return q;
  endfunction

  // frame events only land on ready buffers; direction picks the event kind
  assign rx_ok = rdy_q && (is_tx_i ? rx_remote_i : rx_store_i);

  always_comb begin
    rdy_d = sw_next(rdy_q, set_i[RDY_BIT], clr_i[RDY_BIT]);
    trq_d = tx_done_i ? 1'b0 : sw_next(trq_q, set_i[TRQ_BIT], clr_i[TRQ_BIT]);
    if (rx_ok)                     dn_d = 1'b1;
    else if (tx_done_i && is_tx_i) dn_d = 1'b0;
    else                           dn_d = sw_next(dn_q, set_i[DN_BIT], clr_i[DN_BIT]);
    ovr_d = rx_ok && !is_tx_i && dn_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      trq_q <= 1'b0;
      dn_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      trq_q <= trq_d;
      dn_q  <= dn_d;
      ovr_q <= ovr_d;
    end
  end

  always_comb begin
    flags_o          = '0;
    flags_o[RDY_BIT] = rdy_q;
    flags_o[TRQ_BIT] = trq_q;
    flags_o[DN_BIT]  = dn_q;
  end
  assign ovr_o = ovr_q;

  AST_RX_BLOCKED_NOT_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_q && !dn_q && !set_i[DN_BIT]) |=> !dn_q); // R5
  AST_RX_SETS_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && rx_store_i && !is_tx_i) |=> dn_q); // R6
  AST_OVR_NEEDS_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |-> ($past(dn_q) && !$past(is_tx_i))); // R7
  AST_TX_DONE_CLR_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && is_tx_i && !rx_remote_i) |=> !dn_q); // R8
  AST_TX_DONE_CLR_TRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> !trq_q); // R9
endmodule

// File: rtl/cs_read_mux.sv
module cs_read_mux
  import can_stat_pkg::*;
#(
  parameter int NUM_BUF = 32,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic [NUM_BUF-1:0][FLAG_W-1:0] flags_i,
  input  logic [IDX_W-1:0]               addr_i,
  output logic [7:0]                     rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    rd_data_o[FLAG_W-1:0] = flags_i[addr_i];
  end
endmodule

// File: rtl/can_msg_status_bank.sv
module can_msg_status_bank
  import can_stat_pkg::*;
#(
  parameter int NUM_BUF = 32,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   addr_i,
  output logic [7:0]         rd_data_o,
  input  logic               stat_wr_en_i,
  input  logic [7:0]         stat_wr_data_i,
  input  logic               sc_wr_en_i,
  input  logic [15:0]        sc_wr_data_i,
  input  logic [NUM_BUF-1:0] buf_is_tx_i,
  input  logic [NUM_BUF-1:0] rx_store_i,
  input  logic [NUM_BUF-1:0] rx_remote_i,
  input  logic [NUM_BUF-1:0] tx_done_i,
  output logic [NUM_BUF-1:0] tx_elig_o,
  output logic [NUM_BUF-1:0] tx_remote_o,
  output logic [NUM_BUF-1:0] rx_elig_o,
  output logic [NUM_BUF-1:0] ovr_o
);
  logic [NUM_BUF-1:0][FLAG_W-1:0] set_w, clr_w, flags_w;

  // direct status writes are accepted on the bus but dropped
  logic unused_wr;
  assign unused_wr = stat_wr_en_i ^ (^stat_wr_data_i);

  cs_sc_decode #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) i_dec (
    .sc_wr_en_i  (sc_wr_en_i),
    .addr_i      (addr_i),
    .sc_wr_data_i(sc_wr_data_i),
    .set_o       (set_w),
    .clr_o       (clr_w)
  );

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    cs_flag_cell i_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (set_w[g]),
      .clr_i      (clr_w[g]),
      .is_tx_i    (buf_is_tx_i[g]),
      .rx_store_i (rx_store_i[g]),
      .rx_remote_i(rx_remote_i[g]),
      .tx_done_i  (tx_done_i[g]),
      .flags_o    (flags_w[g]),
      .ovr_o      (ovr_o[g])
    );
    assign tx_elig_o[g]   = flags_w[g][RDY_BIT] && flags_w[g][TRQ_BIT];
    assign tx_remote_o[g] = tx_elig_o[g] && !buf_is_tx_i[g];
    assign rx_elig_o[g]   = flags_w[g][RDY_BIT];
  end

  cs_read_mux #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) i_rd (
    .flags_i  (flags_w),
    .addr_i   (addr_i),
    .rd_data_o(rd_data_o)
  );

  AST_TX_ELIG_NEEDS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_elig_o != '0) |-> (rx_elig_o != '0)); // R4
  AST_RD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:3] == 5'd0); // R1
endmodule

// File: tb/test_can_msg_status_bank.sv
module test_can_msg_status_bank;
  localparam int NB = 32;
  localparam int IW = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [IW-1:0] addr_i = '0;
  logic [7:0]    rd_data_o;
  logic          stat_wr_en_i = 1'b0;
  logic [7:0]    stat_wr_data_i = '0;
  logic          sc_wr_en_i = 1'b0;
  logic [15:0]   sc_wr_data_i = '0;
  logic [NB-1:0] buf_is_tx_i = '0, rx_store_i = '0, rx_remote_i = '0, tx_done_i = '0;
  logic [NB-1:0] tx_elig_o, tx_remote_o, rx_elig_o, ovr_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  can_msg_status_bank #(.NUM_BUF(NB)) i_can_msg_status_bank (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output logic [7:0] v);
    addr_i = IW'(idx);
    #1;
    v = rd_data_o;
  endtask

  task automatic chk_byte(input string req, input int idx, input logic [7:0] exp);
    logic [7:0] v;
    rd(idx, v);
    chk(req, {24'd0, v}, {24'd0, exp});
  endtask

  // word bit k clears flag k, bit 8+k sets flag k
  task automatic sc_wr(input int idx, input logic [2:0] s, input logic [2:0] c);
    @(negedge clk_i);
    addr_i = IW'(idx);
    sc_wr_data_i = {5'd0, s, 5'd0, c};
    sc_wr_en_i = 1'b1;
    @(posedge clk_i);
    #1;
    sc_wr_en_i = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < NB; i++) chk_byte("R11 byte", i, 8'h00);
    chk("R11 tx_elig", tx_elig_o, '0);
    chk("R11 rx_elig", rx_elig_o, '0);
    chk("R11 ovr", ovr_o, '0);
  endtask

  task automatic t_layout();
    sc_wr(5, 3'b001, 3'b000); chk_byte("R1 rdy bit0", 5, 8'h01);
    sc_wr(5, 3'b010, 3'b000); chk_byte("R1 trq bit1", 5, 8'h03);
    sc_wr(5, 3'b100, 3'b000); chk_byte("R1 dn bit2", 5, 8'h07);
    sc_wr(5, 3'b000, 3'b010); chk_byte("R3 clear trq", 5, 8'h05);
    chk_byte("R3 neighbour untouched", 4, 8'h00);
  endtask

  task automatic t_both();
    sc_wr(5, 3'b110, 3'b110);
    chk_byte("R3 set+clear unchanged", 5, 8'h05);
  endtask

  task automatic t_direct();
    @(negedge clk_i);
    addr_i = IW'(6);
    stat_wr_data_i = 8'hFF;
    stat_wr_en_i = 1'b1;
    @(posedge clk_i); #1;
    addr_i = IW'(5);
    stat_wr_data_i = 8'h00;
    @(posedge clk_i); #1;
    stat_wr_en_i = 1'b0;
    chk_byte("R2 direct write ignored", 6, 8'h00);
    chk_byte("R2 direct zero ignored", 5, 8'h05);
  endtask

  task automatic t_elig();
    sc_wr(7, 3'b001, 3'b000);
    chk("R4 rdy only no tx", {31'd0, tx_elig_o[7]}, 32'd0);
    chk("R5 rx_elig follows rdy", {31'd0, rx_elig_o[7]}, 32'd1);
    sc_wr(7, 3'b010, 3'b000);
    chk("R4 rdy+trq tx", {31'd0, tx_elig_o[7]}, 32'd1);
    chk("R4 remote on rx buf", {31'd0, tx_remote_o[7]}, 32'd1);
    buf_is_tx_i[7] = 1'b1; #1;
    chk("R4 no remote on tx buf", {31'd0, tx_remote_o[7]}, 32'd0);
  endtask

  task automatic pulse(ref logic [NB-1:0] v, input int idx);
    @(negedge clk_i);
    v[idx] = 1'b1;
    @(posedge clk_i); #1;
    v[idx] = 1'b0;
  endtask

  task automatic t_rx();
    pulse(rx_store_i, 9);
    chk_byte("R5 frame dropped when not ready", 9, 8'h00);
    sc_wr(9, 3'b001, 3'b000);
    pulse(rx_store_i, 9);
    chk_byte("R6 dn set on store", 9, 8'h05);
    chk("R7 no ovr first frame", {31'd0, ovr_o[9]}, 32'd0);
    repeat (3) @(posedge clk_i);
    #1;
    chk_byte("R6 dn held", 9, 8'h05);
    pulse(rx_store_i, 9);
    chk("R7 ovr pulse", {31'd0, ovr_o[9]}, 32'd1);
    @(posedge clk_i); #1;
    chk("R7 ovr single cycle", {31'd0, ovr_o[9]}, 32'd0);
    sc_wr(9, 3'b000, 3'b100);
    chk_byte("R6 dn cleared by sw", 9, 8'h01);
  endtask

  task automatic t_tx_buf();
    buf_is_tx_i[12] = 1'b1;
    sc_wr(12, 3'b011, 3'b000);
    chk_byte("R8 tx buf ready", 12, 8'h03);
    pulse(rx_remote_i, 12);
    chk_byte("R8 remote sets dn", 12, 8'h07);
    pulse(rx_remote_i, 12);
    chk("R7 tx buf no ovr", {31'd0, ovr_o[12]}, 32'd0);
    pulse(tx_done_i, 12);
    chk_byte("R8 R9 tx done clears dn trq", 12, 8'h01);
    sc_wr(9, 3'b110, 3'b000);
    pulse(tx_done_i, 9);
    chk_byte("R9 rx buf trq cleared dn kept", 9, 8'h05);
  endtask

  task automatic t_prio();
    sc_wr(14, 3'b011, 3'b000);
    @(negedge clk_i);
    addr_i = IW'(14);
    sc_wr_data_i = {5'd0, 3'b010, 5'd0, 3'b000};
    sc_wr_en_i = 1'b1;
    tx_done_i[14] = 1'b1;
    @(posedge clk_i); #1;
    sc_wr_en_i = 1'b0;
    tx_done_i[14] = 1'b0;
    chk_byte("R10 tx done beats sw set trq", 14, 8'h01);
    @(negedge clk_i);
    sc_wr_data_i = {5'd0, 3'b000, 5'd0, 3'b100};
    sc_wr_en_i = 1'b1;
    rx_store_i[14] = 1'b1;
    @(posedge clk_i); #1;
    sc_wr_en_i = 1'b0;
    rx_store_i[14] = 1'b0;
    chk_byte("R10 store beats sw clear dn", 14, 8'h05);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_layout();
    t_both();
    t_direct();
    t_elig();
    t_rx();
    t_tx_buf();
    t_prio();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule